// File: doc/BRIEF.md
# Register-Programmed Clock Rate Divider

This block divides one input clock by an integer taken from a bit field of a single control register. The field sits at a parameterised offset. At elaboration the field is given one of four meanings: the value plus one, the value itself with zero excluded, two raised to the value, or an index into a parameter table where zero entries mark holes. Outside table mode the result must also lie between a minimum and a maximum divisor.

Software writes the control register through a plain write/read port. When the latch option is enabled, a write lands in the register but reaches the divider only if the same write also sets the commit bit. A write that decodes to an illegal divisor leaves the running divisor alone and sets an error flag. Legal divisors first wait in a pending slot and are applied only when the current output period ends. The same register also holds an autoidle enable bit, whose polarity is chosen by a parameter.

Top module: `clkdiv_reg`

## Requirements
- R1: In plus-one mode the divisor is the field value plus one.
- R2: In direct mode the divisor equals the field value, and a field value of 0 is illegal.
- R3: In power-of-two mode the divisor is 2 to the power of the field value.
- R4: In table mode the divisor is table entry number (field value), where entry i occupies bits [i*CNT_W +: CNT_W] of TABLE_FLAT. A zero entry is illegal. MIN_DIV and MAX_DIV do not apply in this mode.
- R5: Outside table mode, a divisor below MIN_DIV or above MAX_DIV is illegal. When a commit is illegal, the running divisor does not change and err_o becomes 1. A legal commit clears err_o. err_o changes only on a write.
- R6: The divisor field occupies wr_data_i[DIV_LSB +: DIV_W]. Bits outside the field, the idle bit and the commit bit have no effect and read back as 0. rd_data_o returns the last written field and idle bit.
- R7: With USE_LATCH=1, a write whose bit LATCH_BIT is 0 only updates the stored field, and a write with that bit at 1 also commits. With USE_LATCH=0, every write commits.
- R8: autoidle_o equals the stored bit IDLE_BIT, inverted when IDLE_INV=1. It changes only on a write.
- R9: A new divisor takes effect only after the running output period completes, so every period is exactly N input cycles.
- R10: For N>1 the output is high for the first floor(N/2) cycles of each period. For N=1, clk_o is clk_i.
- R11: After reset the divisor is the smallest legal value, err_o is 0 and the stored register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register readback |
| clk_o | output | 1 | Divided clock |
| autoidle_o | output | 1 | Autoidle enable, polarity applied |
| err_o | output | 1 | Last commit was illegal |
| cur_div_o | output | CNT_W | Divisor currently in effect |

## Verification
Four instances, one per decoding mode, share a single write bus. A sweep over all sixteen field values, with unrelated bits set, separates legal codes from holes and from values out of range. In each step the active divisor is compared with its arithmetic value, and the high samples over four periods are counted, which tells a correct duty cycle and period apart from one that is off by one. Before the sweep, a write without the commit bit shows the difference between the latched and unlatched variants. A timed write in the middle of a period shows that the switch waits for the period to end.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic [1:0] {
    DEC_PLUS_ONE = 2'd0,
    DEC_DIRECT   = 2'd1,
    DEC_POW2     = 2'd2,
    DEC_TABLE    = 2'd3
  } dec_mode_e;
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
  import clkdiv_pkg::*;
#(
  parameter dec_mode_e   MODE    = DEC_PLUS_ONE,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MIN_DIV = 1,
  parameter int unsigned MAX_DIV = 16,
  parameter logic [(1<<DIV_W)*CNT_W-1:0] TABLE_FLAT = '0
) (
  input  logic [DIV_W-1:0] field_i,
  output logic [CNT_W-1:0] div_o,
  output logic             ok_o
);
  localparam int unsigned WIDE = CNT_W + 1;
  localparam logic [WIDE-1:0] LO  = WIDE'(MIN_DIV);
  localparam logic [WIDE-1:0] HI  = WIDE'(MAX_DIV);
  localparam logic [WIDE-1:0] TOP = WIDE'(1) << CNT_W;

  generate
    if (MODE == DEC_TABLE) begin : g_table
      always_comb begin
        div_o = TABLE_FLAT[field_i*CNT_W +: CNT_W];
        ok_o  = (div_o != '0);
      end
    end else begin : g_arith
      logic [WIDE-1:0] raw;
      logic            fmt_ok;
      if (MODE == DEC_PLUS_ONE) begin : g_p1
        always_comb begin
          raw    = WIDE'(field_i) + WIDE'(1);
          fmt_ok = 1'b1;
        end
      end else if (MODE == DEC_DIRECT) begin : g_dir
        always_comb begin
          raw    = WIDE'(field_i);
          fmt_ok = (field_i != '0);
        end
      end else begin : g_pow
        always_comb begin
          fmt_ok = (int'(field_i) < int'(CNT_W));
          raw    = fmt_ok ? (WIDE'(1) << field_i) : '0;
        end
      end
      always_comb begin
        div_o = raw[CNT_W-1:0];
        ok_o  = fmt_ok && (raw >= LO) && (raw <= HI) && (raw < TOP) && (raw != '0);
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_LSB   = 0,
  parameter int unsigned DIV_W     = 4,
  parameter bit          USE_LATCH = 1'b0,
  parameter int unsigned LATCH_BIT = 31,
  parameter int unsigned IDLE_BIT  = 8,
  parameter bit          IDLE_INV  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              dec_ok_i,
  output logic [DIV_W-1:0]  field_o,
  output logic              load_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              err_o,
  output logic              autoidle_o
);
  logic [DIV_W-1:0] field_q;
  logic             idle_q;
  logic             err_q;
  logic             apply;

  assign field_o = wr_data_i[DIV_LSB +: DIV_W];

  generate
    if (USE_LATCH) begin : g_latch
      assign apply = wr_data_i[LATCH_BIT];
    end else begin : g_direct
      assign apply = 1'b1;
    end
  endgenerate

  assign load_o = wr_en_i && apply && dec_ok_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      field_q <= '0;
      idle_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (wr_en_i) begin
      field_q <= field_o;
      idle_q  <= wr_data_i[IDLE_BIT];
      if (apply) err_q <= !dec_ok_i;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[DIV_LSB +: DIV_W]  = field_q;
    rd_data_o[IDLE_BIT]          = idle_q;
  end

  assign err_o      = err_q;
  assign autoidle_o = idle_q ^ IDLE_INV;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_DIV = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_div_i,
  output logic             clk_o,
  output logic [CNT_W-1:0] cur_div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             div_q_o
);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(RST_DIV);

  logic [CNT_W-1:0] cnt_q, cur_q, pend_q;
  logic             pend_v_q, div_q;
  logic [CNT_W-1:0] nxt_cnt, nxt_cur;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == cur_q - CNT_W'(1));
    nxt_cur = (wrap && pend_v_q) ? pend_q : cur_q;
    nxt_cnt = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      cur_q    <= RST_V;
      pend_q   <= RST_V;
      pend_v_q <= 1'b0;
      div_q    <= (RST_DIV > 1);
    end else begin
      cnt_q <= nxt_cnt;
      cur_q <= nxt_cur;
      div_q <= (nxt_cnt < (nxt_cur >> 1));
      if (load_i) begin
        pend_q   <= load_div_i;
        pend_v_q <= 1'b1;
      end else if (wrap) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign clk_o     = (cur_q == CNT_W'(1)) ? clk_i : div_q;
  assign cur_div_o = cur_q;
  assign cnt_o     = cnt_q;
  assign wrap_o    = wrap;
  assign div_q_o   = div_q;
endmodule

// File: rtl/clkdiv_reg.sv
module clkdiv_reg
  import clkdiv_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_LSB   = 0,
  parameter int unsigned DIV_W     = 4,
  parameter int unsigned CNT_W     = 8,
  parameter dec_mode_e   MODE      = DEC_PLUS_ONE,
  parameter int unsigned MIN_DIV   = 1,
  parameter int unsigned MAX_DIV   = 16,
  parameter logic [(1<<DIV_W)*CNT_W-1:0] TABLE_FLAT = '0,
  parameter bit          USE_LATCH = 1'b0,
  parameter int unsigned LATCH_BIT = 31,
  parameter int unsigned IDLE_BIT  = 8,
  parameter bit          IDLE_INV  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clk_o,
  output logic              autoidle_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  cur_div_o
);
  localparam int unsigned TBL_N = 1 << DIV_W;

  function automatic int unsigned first_legal();
    int unsigned best;
    int unsigned v;
    int unsigned p;
    best = 0;
    if (MODE == DEC_TABLE) begin
      for (int i = 0; i < TBL_N; i++) begin
        v = int'(TABLE_FLAT[i*CNT_W +: CNT_W]);
        if (v != 0 && (best == 0 || v < best)) best = v;
      end
    end else begin
      v = (MIN_DIV < 1) ? 1 : MIN_DIV;
      if (MODE == DEC_POW2) begin
        p = 1;
        for (int i = 0; i < CNT_W; i++) if (p < v) p = p << 1;
        best = p;
      end else begin
        best = v;
      end
    end
    return (best == 0) ? 1 : best;
  endfunction

  localparam int unsigned RST_DIV = first_legal();

  logic [DIV_W-1:0] field_w;
  logic [CNT_W-1:0] dec_div_w;
  logic             dec_ok_w;
  logic             load_w;
  logic [CNT_W-1:0] cnt_w;
  logic             wrap_w;
  logic             div_q_w;

  clkdiv_ctrl #(
    .DATA_W(DATA_W), .DIV_LSB(DIV_LSB), .DIV_W(DIV_W), .USE_LATCH(USE_LATCH),
    .LATCH_BIT(LATCH_BIT), .IDLE_BIT(IDLE_BIT), .IDLE_INV(IDLE_INV)
  ) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .dec_ok_i(dec_ok_w), .field_o(field_w), .load_o(load_w),
    .rd_data_o(rd_data_o), .err_o(err_o), .autoidle_o(autoidle_o)
  );

  clkdiv_decode #(
    .MODE(MODE), .DIV_W(DIV_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV),
    .MAX_DIV(MAX_DIV), .TABLE_FLAT(TABLE_FLAT)
  ) u_dec (
    .field_i(field_w), .div_o(dec_div_w), .ok_o(dec_ok_w)
  );

  clkdiv_core #(
    .CNT_W(CNT_W), .RST_DIV(RST_DIV)
  ) u_core (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_w), .load_div_i(dec_div_w),
    .clk_o(clk_o), .cur_div_o(cur_div_o), .cnt_o(cnt_w), .wrap_o(wrap_w),
    .div_q_o(div_q_w)
  );
endmodule

// File: rtl/clkdiv_reg_chk.sv
module clkdiv_reg_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_en_i,
  input logic             err_o,
  input logic             autoidle_o,
  input logic [CNT_W-1:0] cur_div_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic             wrap_w,
  input logic             div_q_w
);
  a_r9_switch_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_div_o != $past(cur_div_o)) |-> $past(wrap_w));

  a_r9_count_in_period: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_w < cur_div_o);

  a_r10_high_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_w == '0 && cur_div_o > CNT_W'(1)) |-> div_q_w);

  a_r10_low_in_tail: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur_div_o > CNT_W'(1) && cnt_w >= (cur_div_o >> 1)) |-> !div_q_w);

  a_r5_err_on_write_only: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(wr_en_i) |-> $stable(err_o));

  a_r8_idle_on_write_only: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(wr_en_i) |-> $stable(autoidle_o));
endmodule

bind clkdiv_reg clkdiv_reg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .err_o(err_o),
  .autoidle_o(autoidle_o), .cur_div_o(cur_div_o), .cnt_w(cnt_w),
  .wrap_w(wrap_w), .div_q_w(div_q_w)
);

// File: tb/clkdiv_reg_tb.sv
module clkdiv_reg_tb;
  import clkdiv_pkg::*;

  localparam int DW = 32;
  localparam int DL = 4;
  localparam int FW = 4;
  localparam int CW = 8;
  localparam int LB = 31;
  localparam int IB = 12;

  function automatic int tbl_val(int i);
    return (i % 3 == 2) ? 0 : i + 2;
  endfunction

  function automatic logic [16*CW-1:0] mk_tbl();
    logic [16*CW-1:0] t;
    t = '0;
    for (int i = 0; i < 16; i++) t[i*CW +: CW] = CW'(tbl_val(i));
    return t;
  endfunction

  localparam logic [16*CW-1:0] TBL = mk_tbl();

  // k=0 plus-one (latched), 1 direct, 2 power-of-two (idle inverted), 3 table
  function automatic int exp_div(int k, int f);
    case (k)
      0: return (f + 1 <= 12) ? f + 1 : 0;
      1: return (f >= 1 && f <= 12) ? f : 0;
      2: return (f <= 4) ? (1 << f) : 0;
      default: return tbl_val(f);
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_v [4];
  logic [3:0] clk_o_v, idle_v, err_v;
  logic [CW-1:0] cur_v [4];

  always #4 clk = ~clk;

  clkdiv_reg #(.DATA_W(DW), .DIV_LSB(DL), .DIV_W(FW), .CNT_W(CW), .MODE(DEC_PLUS_ONE),
    .MIN_DIV(1), .MAX_DIV(12), .TABLE_FLAT(TBL), .USE_LATCH(1'b1), .LATCH_BIT(LB),
    .IDLE_BIT(IB), .IDLE_INV(1'b0)) u_dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_v[0]),
    .clk_o(clk_o_v[0]), .autoidle_o(idle_v[0]), .err_o(err_v[0]), .cur_div_o(cur_v[0]));

  clkdiv_reg #(.DATA_W(DW), .DIV_LSB(DL), .DIV_W(FW), .CNT_W(CW), .MODE(DEC_DIRECT),
    .MIN_DIV(1), .MAX_DIV(12), .TABLE_FLAT(TBL), .USE_LATCH(1'b0), .LATCH_BIT(LB),
    .IDLE_BIT(IB), .IDLE_INV(1'b0)) u_dut_dir (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_v[1]),
    .clk_o(clk_o_v[1]), .autoidle_o(idle_v[1]), .err_o(err_v[1]), .cur_div_o(cur_v[1]));

  clkdiv_reg #(.DATA_W(DW), .DIV_LSB(DL), .DIV_W(FW), .CNT_W(CW), .MODE(DEC_POW2),
    .MIN_DIV(1), .MAX_DIV(16), .TABLE_FLAT(TBL), .USE_LATCH(1'b0), .LATCH_BIT(LB),
    .IDLE_BIT(IB), .IDLE_INV(1'b1)) u_dut_pow (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_v[2]),
    .clk_o(clk_o_v[2]), .autoidle_o(idle_v[2]), .err_o(err_v[2]), .cur_div_o(cur_v[2]));

  clkdiv_reg #(.DATA_W(DW), .DIV_LSB(DL), .DIV_W(FW), .CNT_W(CW), .MODE(DEC_TABLE),
    .MIN_DIV(1), .MAX_DIV(16), .TABLE_FLAT(TBL), .USE_LATCH(1'b0), .LATCH_BIT(LB),
    .IDLE_BIT(IB), .IDLE_INV(1'b0)) u_dut_tbl (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_v[3]),
    .clk_o(clk_o_v[3]), .autoidle_o(idle_v[3]), .err_o(err_v[3]), .cur_div_o(cur_v[3]));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m_div [4];
  int m_err [4];
  int m_field = 0;
  int m_idle = 0;
  string mode_req [4] = '{"R1", "R2", "R3", "R4"};

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(int f, bit latch, bit idle);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = DW'(f << DL) | (DW'(idle) << IB) | (DW'(latch) << LB) | 32'h000A_000F;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
    m_field = f;
    m_idle  = idle;
    for (int k = 0; k < 4; k++) begin
      if (k != 0 || latch) begin
        if (exp_div(k, f) != 0) begin
          m_div[k] = exp_div(k, f);
          m_err[k] = 0;
        end else begin
          m_err[k] = 1;
        end
      end
    end
  endtask

  task automatic measure(int k, string tag);
    int n;
    int highs;
    n = m_div[k];
    highs = 0;
    for (int i = 0; i < 4 * n; i++) begin
      @(posedge clk); #1;
      highs += int'(clk_o_v[k]);
    end
    chk("R10", $sformatf("%s dut%0d high samples n=%0d", tag, k, n), highs,
        (n == 1) ? 4 : 4 * (n / 2));
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk(mode_req[k], $sformatf("%s dut%0d divisor", tag, k), int'(cur_v[k]), m_div[k]);
      chk("R5", $sformatf("%s dut%0d err", tag, k), int'(err_v[k]), m_err[k]);
      chk("R6", $sformatf("%s dut%0d readback", tag, k), int'(rd_v[k]),
          (m_field << DL) | (m_idle << IB));
      chk("R8", $sformatf("%s dut%0d autoidle", tag, k), int'(idle_v[k]),
          (k == 2) ? (1 - m_idle) : m_idle);
      measure(k, tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_div = '{1, 1, 1, 2};
    m_err = '{0, 0, 0, 0};
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    @(posedge clk); #1;
    for (int k = 0; k < 4; k++) begin
      chk("R11", $sformatf("reset dut%0d divisor", k), int'(cur_v[k]), m_div[k]);
      chk("R11", $sformatf("reset dut%0d err", k), int'(err_v[k]), 0);
      chk("R11", $sformatf("reset dut%0d readback", k), int'(rd_v[k]), 0);
    end
    check_all("reset");

    // R7: write without the commit bit
    do_write(5, 1'b0, 1'b1);
    repeat (40) @(posedge clk);
    #1;
    chk("R7", "uncommitted divisor held", int'(cur_v[0]), 1);
    chk("R7", "unlatched instance applied", int'(cur_v[1]), 5);
    chk("R7", "uncommitted value stored", int'(rd_v[0]), (5 << DL) | (1 << IB));
    check_all("nolatch");

    // Sweep every field value, idle bit toggling
    for (int f = 0; f < 16; f++) begin
      do_write(f, 1'b1, 1'(f & 1));
      repeat (40) @(posedge clk);
      check_all($sformatf("sweep f=%0d", f));
    end

    // R9: write mid-period; switch waits for the period boundary
    do_write(7, 1'b1, 1'b0);
    repeat (40) @(posedge clk);
    begin
      logic prev;
      prev = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(posedge clk); #1;
        if (!prev && clk_o_v[0]) break;
        prev = clk_o_v[0];
      end
    end
    do_write(2, 1'b1, 1'b0);
    // one posedge passed inside do_write (load edge, cnt=1)
    repeat (6) @(posedge clk);
    #1;
    chk("R9", "divisor before boundary", int'(cur_v[0]), 8);
    @(posedge clk); #1;
    chk("R9", "divisor at boundary", int'(cur_v[0]), 3);
    check_all("boundary");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule